// File: doc/BRIEF.md
# Transfer Unit Pacer

This block sets the pace at which active-line video bytes leave an input FIFO for one link lane. Output time is cut into transfer units (TUs) of fixed length. Each TU opens with its data slots, and stuffing fills the slots that remain. A TU holds either the programmed whole number of bytes or that number plus one. A fractional accumulator, kept in thousandths, decides which TUs get the extra byte, so that over time the byte rate follows the ratio of link bandwidth to video bandwidth.

Each pulse on `line_start` captures the configuration inputs and clears the fractional state. The block then stays quiet for an initial wait that it derives from the captured TU size, the minimum byte count and the color format, so that the FIFO can fill. After the wait it emits TUs back to back until the next line start. For every active slot it outputs exactly one of data or stuff. It also outputs a FIFO read strobe, TU first and last markers, and a sticky underflow flag.

Top module: `tu_pacer`

## Requirements
- R1: After reset, and until the first `line_start`, every output is low, including `underflow`.
- R2: The TU length is `cfg_tu_size` with bit 0 forced to zero, so an odd setting of 47 gives TUs of 46 slots.
- R3: After the clock edge that samples `line_start` high, the block stays idle for W cycles and then emits slot 0. W is 64 when the minimum byte count is below 4. Otherwise W is D = max(TU size − minimum, 0) for `cfg_color_fmt` 0 (RGB/4:4:4) and 3, D/2 for fmt 1 (4:2:2), and D/3 for fmt 2 (luma only), with integer division.
- R4: In each TU, slots 0 to owed−1 are data slots and the rest are stuffing. Owed is the minimum byte count or the minimum plus one.
- R5: At the start of each TU the fractional value (0–999) is added to an accumulator. When the sum is 1000 or more, that TU carries one extra byte and 1000 is subtracted.
- R6: Owed is capped at the TU size, so a TU is never longer than its programmed length.
- R7: A `line_start` clears the accumulator and the slot counter, even when it arrives in the middle of a TU.
- R8: In a data slot with `fifo_avail` low, the block sends stuff, does not read, and sets `underflow`. Only reset clears `underflow`. Such a slot still counts toward owed, so later slots keep their positions.
- R9: Configuration changes after the `line_start` edge have no effect until the next `line_start`.
- R10: `tu_first` is high in slot 0 and `tu_last` is high in the final slot of every TU.
- R11: In every active slot exactly one of `slot_data` and `slot_stuff` is high, and `fifo_rd` is high exactly in data slots where `fifo_avail` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_tu_size | input | 7 | TU length in slots; bit 0 is ignored |
| cfg_min_bytes | input | 8 | Whole data bytes per TU |
| cfg_frac_milli | input | 10 | Fractional bytes per TU, in thousandths (0–999) |
| cfg_color_fmt | input | 2 | 0 RGB/4:4:4, 1 4:2:2, 2 luma only, 3 as 0 |
| line_start | input | 1 | One-cycle pulse that starts a new active line |
| fifo_avail | input | 1 | The input FIFO has a byte ready |
| slot_data | output | 1 | This slot carries a data byte |
| slot_stuff | output | 1 | This slot carries stuffing |
| fifo_rd | output | 1 | Pops one byte from the FIFO |
| tu_first | output | 1 | First slot of a TU |
| tu_last | output | 1 | Last slot of a TU |
| underflow | output | 1 | Sticky flag: a data slot found the FIFO empty |

## Verification
On every cycle the assertions check that data and stuff never coincide and that each TU opens with an active slot. They also check that reads happen only when the FIFO has a byte, that a TU end is followed by a TU start unless a new line intervenes, and that underflow never clears once set. Other behaviours need the bench's reference model across whole lines. These are the initial wait for each color format, the placement of extra bytes from the thousandths accumulator, the cap at the TU size, the restart in the middle of a line, and the capture of configuration at line start.

// File: rtl/tu_pacer_pkg.sv
package tu_pacer_pkg;
   typedef enum logic [1:0] {
      FMT_FULL  = 2'd0,
      FMT_HALF  = 2'd1,
      FMT_LUMA  = 2'd2,
      FMT_SPARE = 2'd3
   } color_fmt_e;

   localparam int unsigned FRAC_ONE_DEF  = 1000;
   localparam int unsigned SMALL_MIN_DEF = 4;
   localparam int unsigned LONG_WAIT_DEF = 64;
endpackage

// File: rtl/tu_wait_calc.sv
module tu_wait_calc
   import tu_pacer_pkg::*;
#(
   parameter int TU_W      = 7,
   parameter int MIN_W     = 8,
   parameter int WAIT_W    = 7,
   parameter int SMALL_MIN = SMALL_MIN_DEF,
   parameter int LONG_WAIT = LONG_WAIT_DEF
) (
   input  logic [TU_W-1:0]   tu_len,
   input  logic [MIN_W-1:0]  min_bytes,
   input  logic [1:0]        fmt,
   output logic [WAIT_W-1:0] wait_len
);
   localparam int DW = MIN_W + 1;

   generate
      if (LONG_WAIT >= (1 << WAIT_W)) begin : g_bad_wait
         $error("tu_wait_calc: LONG_WAIT does not fit WAIT_W");
      end
   endgenerate

   logic [DW-1:0] tu_ext, min_ext, diff;

   always_comb begin
      tu_ext  = DW'(tu_len);
      min_ext = DW'(min_bytes);
      diff    = (tu_ext > min_ext) ? (tu_ext - min_ext) : '0;
      if (min_ext < DW'(SMALL_MIN)) begin
         wait_len = WAIT_W'(LONG_WAIT);
      end else begin
         unique case (color_fmt_e'(fmt))
            FMT_HALF: wait_len = WAIT_W'(diff / DW'(2));
            FMT_LUMA: wait_len = WAIT_W'(diff / DW'(3));
            default:  wait_len = WAIT_W'(diff);
         endcase
      end
   end
endmodule

// File: rtl/tu_frac_acc.sv
module tu_frac_acc
   import tu_pacer_pkg::*;
#(
   parameter int FRAC_W   = 10,
   parameter int FRAC_ONE = FRAC_ONE_DEF
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              step,
   input  logic [FRAC_W-1:0] frac,
   output logic              extra
);
   localparam int ACC_W = $clog2(FRAC_ONE);
   localparam int SUM_W = ACC_W + 1;

   generate
      if (FRAC_W < ACC_W) begin : g_bad_frac
         $error("tu_frac_acc: FRAC_W too narrow for FRAC_ONE");
      end
   endgenerate

   logic [ACC_W-1:0] acc;
   logic [SUM_W-1:0] frac_lim, sum;

   always_comb begin
      frac_lim = (frac > FRAC_W'(FRAC_ONE - 1)) ? SUM_W'(FRAC_ONE - 1) : SUM_W'(frac);
      sum      = SUM_W'(acc) + frac_lim;
      extra    = (sum >= SUM_W'(FRAC_ONE));
   end

   always_ff @(posedge clk) begin
      if (!rst_n || clr)  acc <= '0;
      else if (step)      acc <= extra ? ACC_W'(sum - SUM_W'(FRAC_ONE)) : ACC_W'(sum);
   end
endmodule

// File: rtl/tu_pacer.sv
module tu_pacer
   import tu_pacer_pkg::*;
#(
   parameter int TU_W     = 7,
   parameter int MIN_W    = 8,
   parameter int FRAC_W   = 10,
   parameter int WAIT_W   = 7,
   parameter int FRAC_ONE = FRAC_ONE_DEF
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [TU_W-1:0]   cfg_tu_size,
   input  logic [MIN_W-1:0]  cfg_min_bytes,
   input  logic [FRAC_W-1:0] cfg_frac_milli,
   input  logic [1:0]        cfg_color_fmt,
   input  logic              line_start,
   input  logic              fifo_avail,
   output logic              slot_data,
   output logic              slot_stuff,
   output logic              fifo_rd,
   output logic              tu_first,
   output logic              tu_last,
   output logic              underflow
);
   localparam int OW = MIN_W + 1;

   generate
      if (MIN_W < TU_W) begin : g_bad_min
         $error("tu_pacer: MIN_W must be at least TU_W");
      end
   endgenerate

   logic              running;
   logic [WAIT_W-1:0] wait_cnt, wait_next;
   logic [TU_W-1:0]   slot, tu_q, tu_even;
   logic [MIN_W-1:0]  min_q;
   logic [FRAC_W-1:0] frac_q;
   logic [OW-1:0]     owed_q, owed_now, owed_cur, min_plus;
   logic              active, at_first, at_last, data_slot, extra;

   assign tu_even = {cfg_tu_size[TU_W-1:1], 1'b0};

   tu_wait_calc #(.TU_W(TU_W), .MIN_W(MIN_W), .WAIT_W(WAIT_W)) u_wait (
      .tu_len    (tu_even),
      .min_bytes (cfg_min_bytes),
      .fmt       (cfg_color_fmt),
      .wait_len  (wait_next)
   );

   tu_frac_acc #(.FRAC_W(FRAC_W), .FRAC_ONE(FRAC_ONE)) u_acc (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (line_start),
      .step  (at_first),
      .frac  (frac_q),
      .extra (extra)
   );

   always_comb begin
      active    = running && (wait_cnt == '0);
      at_first  = active && (slot == '0);
      at_last   = active && (slot == tu_q - TU_W'(1));
      min_plus  = OW'(min_q) + OW'(extra);
      owed_now  = (min_plus > OW'(tu_q)) ? OW'(tu_q) : min_plus;
      owed_cur  = at_first ? owed_now : owed_q;
      data_slot = active && (OW'(slot) < owed_cur);
   end

   assign slot_data  = data_slot && fifo_avail;
   assign slot_stuff = active && !(data_slot && fifo_avail);
   assign fifo_rd    = data_slot && fifo_avail;
   assign tu_first   = at_first;
   assign tu_last    = at_last;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         running  <= 1'b0;
         wait_cnt <= '0;
         slot     <= '0;
         tu_q     <= '0;
         min_q    <= '0;
         frac_q   <= '0;
         owed_q   <= '0;
      end else if (line_start) begin
         running  <= 1'b1;
         wait_cnt <= wait_next;
         slot     <= '0;
         tu_q     <= tu_even;
         min_q    <= cfg_min_bytes;
         frac_q   <= cfg_frac_milli;
         owed_q   <= '0;
      end else if (running) begin
         if (wait_cnt != '0) begin
            wait_cnt <= wait_cnt - WAIT_W'(1);
         end else begin
            slot <= at_last ? '0 : slot + TU_W'(1);
            if (at_first) owed_q <= owed_now;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)                        underflow <= 1'b0;
      else if (data_slot && !fifo_avail) underflow <= 1'b1;
   end
endmodule

// File: rtl/tu_pacer_chk.sv
module tu_pacer_chk (
   input logic clk,
   input logic rst_n,
   input logic line_start,
   input logic fifo_avail,
   input logic slot_data,
   input logic slot_stuff,
   input logic fifo_rd,
   input logic tu_first,
   input logic tu_last,
   input logic underflow
);
   // R11
   data_stuff_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(slot_data && slot_stuff));

   // R11
   read_needs_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_rd |-> fifo_avail);

   // R10
   tu_opens_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tu_first |-> (slot_data || slot_stuff));

   // R10
   last_then_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tu_last && !line_start) |=> tu_first);

   // R8
   underflow_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      underflow |=> underflow);

   // R8
   underflow_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(underflow) |-> $past(slot_stuff && !fifo_avail));
endmodule

bind tu_pacer tu_pacer_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .line_start (line_start),
   .fifo_avail (fifo_avail),
   .slot_data  (slot_data),
   .slot_stuff (slot_stuff),
   .fifo_rd    (fifo_rd),
   .tu_first   (tu_first),
   .tu_last    (tu_last),
   .underflow  (underflow)
);

// File: tb/tb_tu_pacer.sv
module tb_tu_pacer;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [6:0] cfg_tu_size = '0;
   logic [7:0] cfg_min_bytes = '0;
   logic [9:0] cfg_frac_milli = '0;
   logic [1:0] cfg_color_fmt = '0;
   logic       line_start = 1'b0;
   logic       fifo_avail = 1'b1;
   logic       slot_data, slot_stuff, fifo_rd, tu_first, tu_last, underflow;

   int checks = 0;
   int errors = 0;
   bit model_uf = 1'b0;
   int seed_dummy;

   always #(CLK_PERIOD/2) clk = ~clk;

   tu_pacer dut (
      .clk(clk), .rst_n(rst_n), .cfg_tu_size(cfg_tu_size), .cfg_min_bytes(cfg_min_bytes),
      .cfg_frac_milli(cfg_frac_milli), .cfg_color_fmt(cfg_color_fmt), .line_start(line_start),
      .fifo_avail(fifo_avail), .slot_data(slot_data), .slot_stuff(slot_stuff), .fifo_rd(fifo_rd),
      .tu_first(tu_first), .tu_last(tu_last), .underflow(underflow)
   );

   task automatic check(string req, string label, int got, int exp);
      checks++;
      if (got != exp) begin
         errors++;
         $display("FAIL %s %s: got %0h exp %0h at %0t", req, label, got, exp, $time);
      end
   endtask

   function automatic int exp_wait(int tu, int mn, int fmt);
      int d;
      if (mn < 4) return 64;
      d = (tu > mn) ? tu - mn : 0;
      if (fmt == 1) return d / 2;
      if (fmt == 2) return d / 3;
      return d;
   endfunction

   function automatic bit pick_avail(int mode);
      if (mode == 0) return 1'b1;
      return ($urandom % 8) != 0;
   endfunction

   // Starts a line, then checks W idle cycles, n_tus whole TUs and part_slots of one more.
   task automatic run_line(string label, int tu_raw, int mn, int fr, int fmt,
                           int n_tus, int part_slots, int mode);
      int tu, w, acc, owed, lim, s_sum;
      bit ex, exp_d;
      tu = tu_raw & 'h7E;
      w  = exp_wait(tu, mn, fmt);
      cfg_tu_size = 7'(tu_raw); cfg_min_bytes = 8'(mn);
      cfg_frac_milli = 10'(fr); cfg_color_fmt = 2'(fmt);
      line_start = 1'b1; fifo_avail = 1'b1;
      @(negedge clk);
      line_start = 1'b0;
      // R9: scramble configuration for the rest of the line
      cfg_tu_size = 7'($urandom); cfg_min_bytes = 8'($urandom);
      cfg_frac_milli = 10'($urandom % 1000); cfg_color_fmt = 2'($urandom);
      for (int i = 0; i < w; i++) begin
         fifo_avail = pick_avail(mode);
         #1;
         check("R3", label, {slot_data, slot_stuff, fifo_rd, tu_first, tu_last}, 0);
         check("R8", label, underflow, model_uf);
         @(negedge clk);
      end
      acc = 0;
      for (int t = 0; t <= n_tus; t++) begin
         s_sum = acc + fr;
         ex = (s_sum >= 1000);
         acc = ex ? s_sum - 1000 : s_sum;
         owed = mn + ex;
         if (owed > tu) owed = tu;
         lim = (t == n_tus) ? part_slots : tu;
         for (int s = 0; s < lim; s++) begin
            fifo_avail = pick_avail(mode);
            #1;
            exp_d = (s < owed) && fifo_avail;
            // R4 R5 R6 R11
            check("R4", label, {slot_data, slot_stuff, fifo_rd}, {exp_d, !exp_d, exp_d});
            check("R10", label, {tu_first, tu_last}, {s == 0, s == tu - 1});
            check("R8", label, underflow, model_uf);
            if ((s < owed) && !fifo_avail) model_uf = 1'b1;
            @(negedge clk);
         end
      end
      fifo_avail = 1'b1;
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      errors++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      seed_dummy = $urandom(32'h5eed_1234);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1: idle after reset, no line started yet
      for (int i = 0; i < 6; i++) begin
         fifo_avail = ($urandom % 2) != 0;
         #1;
         check("R1", "reset", {slot_data, slot_stuff, fifo_rd, tu_first, tu_last, underflow}, 0);
         @(negedge clk);
      end
      fifo_avail = 1'b1;
      // R2 odd size, R5 extra byte every second TU
      run_line("R2 odd size 47", 47, 20, 500, 0, 4, 0, 0);
      // R3 small minimum gives the long wait
      run_line("R3 small min", 40, 2, 250, 1, 3, 0, 0);
      // R3 4:2:2 and luma-only divisions
      run_line("R3 fmt 4:2:2", 64, 30, 100, 1, 2, 0, 0);
      run_line("R3 fmt luma", 64, 31, 999, 2, 2, 0, 0);
      // R6 owed capped at TU size
      run_line("R6 cap", 40, 40, 999, 2, 3, 0, 0);
      // R7 restart in mid-TU; the next line must begin from a cleared state
      run_line("R7 partial", 32, 10, 700, 3, 2, 13, 0);
      run_line("R7 after restart", 32, 10, 700, 0, 3, 0, 0);
      check("R8", "no empty yet", underflow, 0);
      // R8 FIFO runs dry in the middle of data
      run_line("R8 random empty", 50, 30, 333, 0, 4, 0, 1);
      for (int k = 0; k < 25; k++) begin
         int tu, mn;
         tu = 32 + 2 * ($urandom % 17);
         mn = $urandom % (tu + 1);
         run_line("R9 random", tu, mn, $urandom % 1000, $urandom % 4,
                  1 + $urandom % 4, $urandom % tu, $urandom % 2);
      end
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule